// File: doc/BRIEF.md
# UART Processor Register Bank

This block is the host-side register file of a classic 8-bit UART. A processor reaches it through a 3-bit address, a chip select and separate read and write strobes. The block stores the line settings, the modem-control bits, the interrupt enables, a scratch byte and the 16-bit baud divisor. It drives the four active-low modem control pins. It gathers status from a separate frame engine, which supplies flag ports for holding-register-empty, transmitter-idle and received-byte-valid. From that status it builds the line-status, modem-status and interrupt-identification bytes.

The divisor bytes have no addresses of their own. They sit behind the data and interrupt-enable addresses and are selected by the top bit of line control. A write to the data address with that bit clear hands a byte to the frame engine through a one-cycle load pulse. Read data is registered and appears one clock after the read strobe. The clear-on-read side effects take place on that same clock edge.

Top module: `uart_regbank`

## Requirements
- R1: While `rst` is high, `dtr_n`, `rts_n`, `out1_n` and `out2_n` are all 1 and `rdata` is 0x00.
- R2: With modem-control bit 4 clear, a modem-control write sets {`out2_n`,`out1_n`,`rts_n`,`dtr_n`} to the complement of write bits 3..0 at the clock edge that takes the write.
- R3: With modem-control bit 4 (loop) set, all four modem pins are 1 whatever bits 3..0 hold.
- R4: Address map: 0 = receive data (read) / transmit data (write), 1 = interrupt enable, 2 = interrupt identification, 3 = line control, 4 = modem control, 5 = line status, 6 = modem status, 7 = scratch. When line-control bit 7 is 1, address 0 reads and writes the divisor low byte and address 1 the divisor high byte. The `divisor` port shows {high,low}, and `line_ctrl` shows line control.
- R5: Line control, interrupt enable, scratch and both divisor bytes read back the last value written. Modem control reads back bits 4..0 as written and bits 7..5 as 0.
- R6: Line status is {0, `tx_idle`, `thr_empty`, 0000, data-ready}. After reset, with both transmit flags high, it reads 0x60.
- R7: A `rx_valid` pulse stores `rx_byte` and sets data-ready. A read of address 0 with line-control bit 7 clear returns that byte and clears data-ready. A read of address 0 with bit 7 set leaves data-ready unchanged.
- R8: Interrupt identification reads 0x04 when enable bit 0 is set and data is ready. Otherwise it reads 0x02 when transmit-empty is pending. Otherwise it reads 0x00 when enable bit 3 is set and any modem delta bit is set. Otherwise it reads 0x01.
- R9: Transmit-empty becomes pending when (enable bit 1 AND `thr_empty`) rises. It is cleared by a read of identification that returns 0x02, or by a transmit-data write.
- R10: A write of address 0 with line-control bit 7 clear gives a one-cycle `tx_load` pulse in the cycle after the write, with `tx_byte` equal to the written value.
- R11: Modem status is {DCD,RI,DSR,CTS, dDCD,TERI,dDSR,dCTS}. The upper nibble is the complement of `dcd_n`,`ri_n`,`dsr_n`,`cts_n`. A delta bit is set by any change of CTS, DSR or DCD, or by RI going from 1 to 0. A read of modem status clears the delta bits. After reset with all inputs high it reads 0x00.
- R12: In loop mode the modem-status upper nibble takes CTS from modem-control bit 1, DSR from bit 0, RI from bit 2 and DCD from bit 3.
- R13: `rdata` changes only on the clock edge after a cycle with `cs` and `rd` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| thr_empty | input | 1 | Transmit holding register empty, from the frame engine |
| tx_idle | input | 1 | Transmitter fully idle, from the frame engine |
| rx_valid | input | 1 | One-cycle pulse: a received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| tx_load | output | 1 | One-cycle pulse: a new transmit byte is on `tx_byte` |
| tx_byte | output | 8 | Byte to transmit |
| divisor | output | 16 | Baud divisor {high, low} |
| line_ctrl | output | 8 | Line control register |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| out1_n | output | 1 | User output 1, active low |
| out2_n | output | 1 | User output 2, active low |

## Verification
The bench checks the shared addresses. It reads the interrupt-enable byte again after the divisor high byte has been written at the same address, so a design without a bank-select bit returns the divisor instead. It also checks that a divisor-bank read of address 0 leaves data-ready set, and that a transmit write leaves the divisor unchanged. For the interrupts, all three sources are made pending at once and then drained one by one, which exposes a wrong priority or a source that does not clear on read. Loop mode is entered with all modem bits set and left with all of them clear. This must hold the pins high and produce each modem delta, including the trailing-edge ring bit that a plain change detector would set on the wrong edge.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam logic [2:0] ADR_DATA = 3'd0;
  localparam logic [2:0] ADR_IEN  = 3'd1;
  localparam logic [2:0] ADR_IID  = 3'd2;
  localparam logic [2:0] ADR_LCTL = 3'd3;
  localparam logic [2:0] ADR_MCTL = 3'd4;
  localparam logic [2:0] ADR_LSTS = 3'd5;
  localparam logic [2:0] ADR_MSTS = 3'd6;
  localparam logic [2:0] ADR_SCR  = 3'd7;

  typedef enum logic [1:0] {SRC_NONE, SRC_MODEM, SRC_TXE, SRC_RXD} irq_src_e;

  function automatic logic [7:0] iid_code(irq_src_e s);
    case (s)
      SRC_RXD:   return 8'h04;
      SRC_TXE:   return 8'h02;
      SRC_MODEM: return 8'h00;
      default:   return 8'h01;
    endcase
  endfunction
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode #(
  parameter int AW = 3
) (
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  output logic [(1<<AW)-1:0] rd_sel,
  output logic [(1<<AW)-1:0] wr_sel
);
  localparam int NREG = 1 << AW;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      rd_sel[i] = cs && rd && (addr == AW'(i));
      wr_sel[i] = cs && wr && (addr == AW'(i));
    end
  end
endmodule

// File: rtl/uart_rb_modem.sv
module uart_rb_modem #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mctl_wr,
  input  logic [4:0]    mctl_wdata,
  input  logic          msts_rd,
  input  logic          cts_n,
  input  logic          dsr_n,
  input  logic          ri_n,
  input  logic          dcd_n,
  output logic [DW-1:0] mctl,
  output logic [DW-1:0] msts,
  output logic          delta_any,
  output logic          dtr_n,
  output logic          rts_n,
  output logic          out1_n,
  output logic          out2_n
);
  logic [4:0] mctl_q;
  logic [3:0] line_q;   // {DCD,RI,DSR,CTS}
  logic [3:0] delta_q;  // {dDCD,TERI,dDSR,dCTS}
  logic [3:0] line_nx;
  logic [3:0] chg;
  logic       loop_on;

  assign loop_on = mctl_q[4];

  always_ff @(posedge clk) begin
    if (rst) begin
      mctl_q <= '0;
      {out2_n, out1_n, rts_n, dtr_n} <= 4'hF;
    end else if (mctl_wr) begin
      mctl_q <= mctl_wdata;
      {out2_n, out1_n, rts_n, dtr_n} <= mctl_wdata[4] ? 4'hF : ~mctl_wdata[3:0];
    end
  end

  always_comb begin
    if (loop_on) line_nx = {mctl_q[3], mctl_q[2], mctl_q[0], mctl_q[1]};
    else         line_nx = {~dcd_n, ~ri_n, ~dsr_n, ~cts_n};
    chg[0] = line_nx[0] ^ line_q[0];
    chg[1] = line_nx[1] ^ line_q[1];
    chg[2] = line_q[2] & ~line_nx[2];
    chg[3] = line_nx[3] ^ line_q[3];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= '0;
      delta_q <= '0;
    end else begin
      line_q  <= line_nx;
      delta_q <= (msts_rd ? 4'h0 : delta_q) | chg;
    end
  end

  assign mctl      = DW'(mctl_q);
  assign msts      = DW'({line_q, delta_q});
  assign delta_any = |delta_q;
endmodule

// File: rtl/uart_rb_intr.sv
module uart_rb_intr
  import uart_regbank_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    ien,
  input  logic          thr_empty,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rbuf_rd,
  input  logic          iid_rd,
  input  logic          thr_wr,
  input  logic          modem_delta,
  output logic          data_rdy,
  output logic [DW-1:0] rbuf,
  output logic [DW-1:0] iid
);
  logic     txe_arm, txe_arm_q, txe_pend;
  irq_src_e src;

  assign txe_arm = ien[1] & thr_empty;

  always_comb begin
    if (ien[0] && data_rdy)          src = SRC_RXD;
    else if (txe_pend && ien[1])     src = SRC_TXE;
    else if (ien[3] && modem_delta)  src = SRC_MODEM;
    else                             src = SRC_NONE;
  end

  assign iid = DW'(iid_code(src));

  always_ff @(posedge clk) begin
    if (rst) begin
      data_rdy  <= 1'b0;
      rbuf      <= '0;
      txe_arm_q <= 1'b0;
      txe_pend  <= 1'b0;
    end else begin
      txe_arm_q <= txe_arm;
      if (rx_valid) begin
        data_rdy <= 1'b1;
        rbuf     <= rx_byte;
      end else if (rbuf_rd) begin
        data_rdy <= 1'b0;
      end
      if (txe_arm && !txe_arm_q)
        txe_pend <= 1'b1;
      else if (thr_wr || !ien[1] || (iid_rd && src == SRC_TXE))
        txe_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs,
  input  logic            rd,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic            thr_empty,
  input  logic            tx_idle,
  input  logic            rx_valid,
  input  logic [DW-1:0]   rx_byte,
  output logic            tx_load,
  output logic [DW-1:0]   tx_byte,
  output logic [2*DW-1:0] divisor,
  output logic [DW-1:0]   line_ctrl,
  input  logic            cts_n,
  input  logic            dsr_n,
  input  logic            ri_n,
  input  logic            dcd_n,
  output logic            dtr_n,
  output logic            rts_n,
  output logic            out1_n,
  output logic            out2_n
);
  localparam int NREG = 1 << AW;

  logic [NREG-1:0] rd_sel, wr_sel;
  logic [DW-1:0]   lctl, ien, scr, div_lo, div_hi;
  logic [DW-1:0]   mctl, msts, iid, rbuf, lsts;
  logic [DW-1:0]   regv [NREG];
  logic [DW-1:0]   rd_mux;
  logic            bank, delta_any, dr_flag;
  logic            thr_wr, rbuf_rd;
  logic            unused_wr;

  uart_rb_decode #(.AW(AW)) u_dec (
    .cs(cs), .rd(rd), .wr(wr), .addr(addr), .rd_sel(rd_sel), .wr_sel(wr_sel)
  );

  assign bank      = lctl[7];
  assign thr_wr    = wr_sel[ADR_DATA] && !bank;
  assign rbuf_rd   = rd_sel[ADR_DATA] && !bank;
  assign unused_wr = ^{wr_sel[ADR_IID], wr_sel[ADR_LSTS], wr_sel[ADR_MSTS]};

  always_ff @(posedge clk) begin
    if (rst) begin
      lctl    <= '0;
      ien     <= '0;
      scr     <= '0;
      div_lo  <= '0;
      div_hi  <= '0;
      tx_load <= 1'b0;
      tx_byte <= '0;
    end else begin
      tx_load <= thr_wr;
      if (thr_wr)                           tx_byte <= wdata;
      if (wr_sel[ADR_DATA] && bank)         div_lo  <= wdata;
      if (wr_sel[ADR_IEN] && bank)          div_hi  <= wdata;
      if (wr_sel[ADR_IEN] && !bank)         ien     <= wdata;
      if (wr_sel[ADR_LCTL])                 lctl    <= wdata;
      if (wr_sel[ADR_SCR])                  scr     <= wdata;
    end
  end

  uart_rb_modem #(.DW(DW)) u_modem (
    .clk(clk), .rst(rst),
    .mctl_wr(wr_sel[ADR_MCTL]), .mctl_wdata(wdata[4:0]),
    .msts_rd(rd_sel[ADR_MSTS]),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .mctl(mctl), .msts(msts), .delta_any(delta_any),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n)
  );

  uart_rb_intr #(.DW(DW)) u_intr (
    .clk(clk), .rst(rst), .ien(ien[3:0]),
    .thr_empty(thr_empty), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rbuf_rd(rbuf_rd), .iid_rd(rd_sel[ADR_IID]), .thr_wr(thr_wr),
    .modem_delta(delta_any),
    .data_rdy(dr_flag), .rbuf(rbuf), .iid(iid)
  );

  assign lsts = DW'({tx_idle, thr_empty, 4'b0000, dr_flag});

  always_comb begin
    regv[ADR_DATA] = bank ? div_lo : rbuf;
    regv[ADR_IEN]  = bank ? div_hi : ien;
    regv[ADR_IID]  = iid;
    regv[ADR_LCTL] = lctl;
    regv[ADR_MCTL] = mctl;
    regv[ADR_LSTS] = lsts;
    regv[ADR_MSTS] = msts;
    regv[ADR_SCR]  = scr;
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_sel[i]) rd_mux = rd_mux | regv[i];
  end

  always_ff @(posedge clk) begin
    if (rst)             rdata <= '0;
    else if (cs && rd)   rdata <= rd_mux;
  end

  assign divisor   = {div_hi, div_lo};
  assign line_ctrl = lctl;
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          cs,
  input logic          rd,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          rx_valid,
  input logic [DW-1:0] line_ctrl,
  input logic          dr_flag,
  input logic          dtr_n,
  input logic          rts_n,
  input logic          out1_n,
  input logic          out2_n
);
  assert_reset_pins_R1: assert property (@(posedge clk)
    rst |=> (dtr_n && rts_n && out1_n && out2_n));

  assert_mctl_drive_R2: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == AW'(4) && !wdata[4])
      |=> ({out2_n, out1_n, rts_n, dtr_n} == ~$past(wdata[3:0])));

  assert_loop_force_R3: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == AW'(4) && wdata[4])
      |=> (dtr_n && rts_n && out1_n && out2_n));

  assert_rbuf_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && addr == AW'(0) && !line_ctrl[7] && !rx_valid) |=> !dr_flag);

  assert_iid_code_R8: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && addr == AW'(2))
      |=> (rdata == DW'(8'h01) || rdata == DW'(8'h02) ||
           rdata == DW'(8'h04) || rdata == DW'(8'h00)));

  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd) |=> $stable(rdata));
endmodule

bind uart_regbank uart_regbank_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
  .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .line_ctrl(line_ctrl),
  .dr_flag(dr_flag), .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n),
  .out2_n(out2_n)
);

// File: tb/tb_uart_regbank.sv
`timescale 1ns/1ps
module tb_uart_regbank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs = 0, rd = 0, wr = 0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        thr_empty = 1, tx_idle = 1, rx_valid = 0;
  logic [7:0]  rx_byte = '0;
  logic        tx_load;
  logic [7:0]  tx_byte;
  logic [15:0] divisor;
  logic [7:0]  line_ctrl;
  logic        cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic        dtr_n, rts_n, out1_n, out2_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_regbank dut (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .thr_empty(thr_empty), .tx_idle(tx_idle),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_load(tx_load),
    .tx_byte(tx_byte), .divisor(divisor), .line_ctrl(line_ctrl),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n)
  );

  // vector: {is_read, addr[2:0], wdata[7:0], expected[7:0]}
  localparam int NV = 17;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd3, 8'h1B, 8'h00},   // R5 line control
    {1'b1, 3'd3, 8'h00, 8'h1B},
    {1'b0, 3'd7, 8'hA5, 8'h00},   // R5 scratch
    {1'b1, 3'd7, 8'h00, 8'hA5},
    {1'b0, 3'd1, 8'h0D, 8'h00},   // R5 interrupt enable
    {1'b1, 3'd1, 8'h00, 8'h0D},
    {1'b0, 3'd3, 8'h9B, 8'h00},   // R4 open divisor bank
    {1'b0, 3'd0, 8'h34, 8'h00},
    {1'b0, 3'd1, 8'h12, 8'h00},
    {1'b1, 3'd0, 8'h00, 8'h34},
    {1'b1, 3'd1, 8'h00, 8'h12},
    {1'b1, 3'd3, 8'h00, 8'h9B},
    {1'b0, 3'd3, 8'h1B, 8'h00},   // R4 close divisor bank
    {1'b1, 3'd1, 8'h00, 8'h0D},   // enable kept apart from divisor high
    {1'b0, 3'd4, 8'hEA, 8'h00},   // R5 modem control upper bits drop
    {1'b1, 3'd4, 8'h00, 8'h0A},
    {1'b1, 3'd5, 8'h00, 8'h60}    // R6 line status
  };

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic rreg(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1; rd = 1; addr = a;
    @(negedge clk);
    cs = 0; rd = 0;
    d = rdata;
  endtask

  task automatic rchk(string req, logic [2:0] a, logic [7:0] exp);
    logic [7:0] d;
    rreg(a, d);
    chk(req, {8'h00, d}, {8'h00, exp});
  endtask

  task automatic rx_pulse(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_byte = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  function automatic logic [3:0] pins();
    return {out2_n, out1_n, rts_n, dtr_n};
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    tick(3);
    chk("R1 pins in reset", {12'h0, pins()}, 16'h000F);
    chk("R1 rdata in reset", {8'h0, rdata}, 16'h0000);
    rst = 0;
    tick(2);
    chk("R1 pins after reset", {12'h0, pins()}, 16'h000F);
    rchk("R6 line status reset", 3'd5, 8'h60);
    rchk("R11 modem status reset", 3'd6, 8'h00);
    rchk("R8 no interrupt", 3'd2, 8'h01);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) rchk($sformatf("R5 vector %0d", i), VEC[i][18:16], VEC[i][7:0]);
      else            wreg(VEC[i][18:16], VEC[i][15:8]);
    end
    chk("R4 divisor port", divisor, 16'h1234);
    chk("R4 line_ctrl port", {8'h0, line_ctrl}, 16'h001B);

    // R2 / R3 modem pins, R12 loop status
    wreg(3'd4, 8'h05);
    chk("R2 pins 05", {12'h0, pins()}, 16'h000A);
    wreg(3'd4, 8'h0A);
    chk("R2 pins 0A", {12'h0, pins()}, 16'h0005);
    wreg(3'd4, 8'h1F);
    chk("R3 loop pins high", {12'h0, pins()}, 16'h000F);
    rchk("R5 modem control loop", 3'd4, 8'h1F);
    tick(2);
    rchk("R8 modem source", 3'd2, 8'h00);
    rchk("R12 loop status on", 3'd6, 8'hFB);
    rchk("R12 deltas cleared", 3'd6, 8'hF0);
    rchk("R8 none after modem read", 3'd2, 8'h01);
    wreg(3'd4, 8'h10);
    chk("R3 loop pins all clear bits", {12'h0, pins()}, 16'h000F);
    tick(2);
    rchk("R12 loop status off", 3'd6, 8'h0F);
    rchk("R11 deltas cleared", 3'd6, 8'h00);
    wreg(3'd4, 8'h00);
    chk("R2 pins 00", {12'h0, pins()}, 16'h000F);

    // R11 external modem inputs
    cts_n = 0; tick(2);
    rchk("R11 cts asserted", 3'd6, 8'h11);
    rchk("R11 cts delta cleared", 3'd6, 8'h10);
    ri_n = 0; tick(2);
    rchk("R11 ring leading edge", 3'd6, 8'h50);
    ri_n = 1; tick(2);
    rchk("R11 ring trailing edge", 3'd6, 8'h14);
    cts_n = 1; tick(2);
    rchk("R11 cts released", 3'd6, 8'h01);
    rchk("R11 idle", 3'd6, 8'h00);
    d = rdata; tick(3);
    chk("R13 rdata held", {8'h0, rdata}, {8'h0, d});

    // R7 receive path
    wreg(3'd1, 8'h01);
    rx_pulse(8'hC3);
    rchk("R6 data ready", 3'd5, 8'h61);
    rchk("R8 rx source", 3'd2, 8'h04);
    rchk("R7 receive byte", 3'd0, 8'hC3);
    rchk("R7 data ready cleared", 3'd5, 8'h60);
    rchk("R8 none after rx", 3'd2, 8'h01);
    rx_pulse(8'h3C);
    wreg(3'd3, 8'h9B);
    rchk("R4 bank read addr0", 3'd0, 8'h34);
    wreg(3'd3, 8'h1B);
    rchk("R7 ready kept by bank read", 3'd5, 8'h61);
    rchk("R7 second byte", 3'd0, 8'h3C);
    thr_empty = 0; tx_idle = 0; tick(1);
    rchk("R6 transmit busy", 3'd5, 8'h00);
    thr_empty = 1; tx_idle = 1;

    // R9 / R10 transmit empty
    wreg(3'd1, 8'h02);
    tick(2);
    rchk("R9 pending after enable", 3'd2, 8'h02);
    rchk("R9 cleared by read", 3'd2, 8'h01);
    thr_empty = 0; tick(1);
    thr_empty = 1; tick(2);
    wreg(3'd0, 8'h77);
    chk("R10 load pulse", {15'h0, tx_load}, 16'h0001);
    chk("R10 load byte", {8'h0, tx_byte}, 16'h0077);
    tick(1);
    chk("R10 pulse ends", {15'h0, tx_load}, 16'h0000);
    rchk("R9 cleared by write", 3'd2, 8'h01);
    chk("R4 divisor kept by data write", divisor, 16'h1234);

    // R8 priority with all sources pending
    wreg(3'd1, 8'h00);
    tick(1);
    cts_n = 0;
    wreg(3'd1, 8'h0B);
    tick(2);
    rx_pulse(8'h5A);
    rchk("R8 rx first", 3'd2, 8'h04);
    rchk("R7 priority byte", 3'd0, 8'h5A);
    rchk("R8 txe second", 3'd2, 8'h02);
    rchk("R8 modem third", 3'd2, 8'h00);
    rchk("R11 modem pending", 3'd6, 8'h11);
    rchk("R8 all drained", 3'd2, 8'h01);
    cts_n = 1;

    tick(2);
    done = 1;
    summary();
    $finish;
  end
endmodule